// File: doc/BRIEF.md
# HDLC Receive Byte Packer

This block sits behind an HDLC receive deframer, which has already found the flags, removed the stuffed bits and checked the CRC. It takes the recovered bytes and the frame boundaries and packs them into a 64-byte receive queue that a host drains through a first-word-fall-through read port. Each frame may keep or drop its leading address byte and its two trailing CRC bytes. The choice is made when the frame starts. Every closed frame gets a status byte appended to the queue, and an end-of-frame event reports how many data bytes were stored and what that status byte holds.

A second event, the block event, tells the host that another block of bytes has been written, so the host can read in fixed-size bursts. A 2-bit code sets the block size. The code is sampled only when a receiver-reset command or a message-done command arrives, so the host can stage a new size without disturbing the block it is reading. A receiver reset also empties the queue and abandons any frame in progress.

The queue keeps its last slot for status bytes. When a frame runs into a full queue, the rest of its data is dropped and the overflow bit in its status is raised.

Top module: `hdlc_rx_packer`

## Requirements
- R1: `blk_ready` pulses for one cycle, in the cycle after the write, each time the count of bytes written into the queue since the last command reaches the block size. Data bytes and status bytes both count. The active code maps to a size as follows: 2'b00 is 32, 2'b01 is 16, 2'b10 is 8 and 2'b11 is 4. The code is 2'b00 after `rst_n`.
- R2: The active block-size code is loaded from `cfg_blk_code` only in a cycle with `cmd_rx_reset` or `cmd_msg_done` high. The same command restarts the block count. Changing `cfg_blk_code` at any other time has no effect.
- R3: A byte beat with `in_sof` high starts a frame. Its byte is the address byte. The address byte is written into the queue if `cfg_store_addr` is 1 on that beat, and is dropped if it is 0.
- R4: If `cfg_store_crc` was 0 on the frame's start beat, the last two bytes received before the end strobe are dropped. If it was 1, every received byte is stored. Changing `cfg_store_crc` later in the frame does not affect that frame.
- R5: An `in_eof` strobe inside a frame closes the frame. The strobe carries no byte. It appends a status byte: bit 0 is `in_crc_ok`, bit 1 is `in_abort`, bit 2 is overflow, and bits 7:3 are zero. In the next cycle it pulses `eof_evt`, with `eof_count` equal to the number of data bytes the frame stored and `eof_status` equal to that status byte.
- R6: The queue holds 64 bytes and keeps their order. `rd_data` shows the oldest byte while `rd_nonempty` is 1. `rd_en` pops that byte at the clock edge. `rd_level` gives the number of stored bytes.
- R7: A data byte is written only while `rd_level` is below 63. Once a byte of a frame is refused, the rest of that frame's data is dropped and its status byte has bit 2 set. The status byte is written if `rd_level` is below 64. If it cannot be written, bit 2 is still set in `eof_status`.
- R8: `cmd_rx_reset` empties the queue (`rd_level` is 0 in the next cycle), abandons the frame in progress, and clears any `blk_ready` or `eof_evt` pulse.
- R9: Byte beats without `in_sof` outside a frame, and `in_eof` strobes outside a frame, write nothing and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present on `in_byte` |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | With `in_valid`: this byte opens a frame |
| in_eof | input | 1 | Frame-close strobe, carries no byte |
| in_crc_ok | input | 1 | CRC result, sampled with `in_eof` |
| in_abort | input | 1 | Frame aborted, sampled with `in_eof` |
| cfg_store_addr | input | 1 | Keep the address byte of a starting frame |
| cfg_store_crc | input | 1 | Keep the CRC bytes, sampled at frame start |
| cfg_blk_code | input | 2 | Staged block-size code |
| cmd_rx_reset | input | 1 | Flush the queue, load the code, restart the block count |
| cmd_msg_done | input | 1 | Load the code and restart the block count |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte of the queue |
| rd_nonempty | output | 1 | The queue holds at least one byte |
| rd_level | output | 7 | Number of bytes stored |
| blk_ready | output | 1 | A block has been written |
| eof_evt | output | 1 | A frame closed |
| eof_count | output | 8 | Data bytes stored for the closed frame |
| eof_status | output | 8 | Status of the closed frame |

## Verification
A wrong hold-back count or a stale frame-start latch makes bytes appear or disappear in the next drain. `eof_count` also disagrees with the host's count in the cycle after the end strobe. A block counter that skips or repeats a value moves `blk_ready` away from the expected byte count within one block, at most 32 writes. A corrupted fill level shows at `rd_level` at once and leads to refused writes or a wrong overflow bit. The bench therefore compares every drained byte, every `eof_count`/`eof_status` pair and the number of block pulses per frame against a model kept in the bench.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

  localparam int unsigned QUEUE_DEPTH = 64;
  localparam int unsigned BLK_W       = 6;

  // Block size for a 2-bit code: 32 halved once per code step.
  function automatic logic [BLK_W-1:0] blk_size(input logic [1:0] code);
    return BLK_W'(32) >> code;
  endfunction

  // Layout of the appended frame status byte.
  function automatic logic [7:0] make_status(input logic crc_ok,
                                             input logic aborted,
                                             input logic ovf);
    return {5'b0, ovf, aborted, crc_ok};
  endfunction

endpackage

// File: rtl/rxp_frame_filter.sv
module rxp_frame_filter
  import rxp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  input  logic             in_abort,
  input  logic             cfg_store_addr,
  input  logic             cfg_store_crc,
  input  logic             room_data,
  input  logic             room_stat,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             eof_evt,
  output logic [CNT_W-1:0] eof_count,
  output logic [7:0]       eof_status
);

  logic             in_frame, keep_crc, ovf;
  logic [1:0]       hcnt;
  logic [7:0]       hold0, hold1;
  logic [CNT_W-1:0] fcnt;

  // Named internal events
  logic       start, beat, close, addr_drop, keep_now, have;
  logic       ovf_now, data_req, data_wr, drop_ovf, stat_wr;
  logic [1:0] h_now;
  logic [7:0] cand, status;

  always_comb begin
    beat      = in_valid && !in_eof && (in_frame || in_sof);
    start     = beat && in_sof;
    close     = in_eof && in_frame;
    keep_now  = start ? cfg_store_crc : keep_crc;
    h_now     = start ? 2'd0 : hcnt;
    ovf_now   = start ? 1'b0 : ovf;
    addr_drop = start && !cfg_store_addr;
    have      = 1'b0;
    cand      = in_byte;
    if (!addr_drop) begin
      if (keep_now) begin
        have = 1'b1;
      end else if (h_now == 2'd2) begin
        have = 1'b1;
        cand = hold0;
      end
    end
    data_req = !flush && beat && have && !ovf_now;
    data_wr  = data_req && room_data;
    drop_ovf = data_req && !room_data;
    stat_wr  = !flush && close && room_stat;
    status   = make_status(in_crc_ok, in_abort, ovf || !room_stat);
    wr_en    = data_wr || stat_wr;
    wr_data  = stat_wr ? status : cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      keep_crc   <= 1'b0;
      ovf        <= 1'b0;
      hcnt       <= 2'd0;
      hold0      <= 8'h00;
      hold1      <= 8'h00;
      fcnt       <= '0;
      eof_evt    <= 1'b0;
      eof_count  <= '0;
      eof_status <= 8'h00;
    end else if (flush) begin
      in_frame <= 1'b0;
      ovf      <= 1'b0;
      hcnt     <= 2'd0;
      fcnt     <= '0;
      eof_evt  <= 1'b0;
    end else begin
      eof_evt <= close;
      if (close) begin
        in_frame   <= 1'b0;
        eof_count  <= fcnt;
        eof_status <= status;
      end
      if (beat) begin
        if (start) begin
          in_frame <= 1'b1;
          keep_crc <= cfg_store_crc;
          ovf      <= drop_ovf;
          fcnt     <= CNT_W'(data_wr);
        end else begin
          ovf  <= ovf || drop_ovf;
          fcnt <= fcnt + CNT_W'(data_wr);
        end
        // Hold-back line, used only when the CRC bytes are being dropped.
        if (!keep_now && !addr_drop) begin
          case (h_now)
            2'd0:    begin hold0 <= in_byte; hcnt <= 2'd1; end
            2'd1:    begin hold1 <= in_byte; hcnt <= 2'd2; end
            default: begin hold0 <= hold1; hold1 <= in_byte; hcnt <= 2'd2; end
          endcase
        end else if (start) begin
          hcnt <= 2'd0;
        end
      end
    end
  end

  // R3: a dropped address byte never reaches the queue
  p_addr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !in_eof && !cfg_store_addr) |-> !data_wr)
    else $error("address byte written although dropping was selected");

  // R5: an end-of-frame event only follows a closing strobe
  p_eof_follows_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eof_evt |-> $past(in_eof) && !$past(flush))
    else $error("eof event without a close strobe");

  // R7: once a frame has overflowed, its data writes stop
  p_ovf_stops_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(in_valid && in_sof)) |-> !data_wr)
    else $error("data written after overflow");

  // R9: no write without an open frame or a starting beat
  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !(in_valid && in_sof)) |-> !wr_en)
    else $error("write outside a frame");

endmodule

// File: rtl/rxp_byte_fifo.sv
module rxp_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_nonempty,
  output logic [LW-1:0] level,
  output logic          room_data,
  output logic          room_stat
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop, push;

  always_comb begin
    rd_nonempty = (level != '0);
    pop         = rd_en && rd_nonempty;
    push        = wr_en && (level < LW'(DEPTH));
    room_data   = (level < LW'(DEPTH - 1));
    room_stat   = (level < LW'(DEPTH));
    rd_data     = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push);
      rd_ptr <= rd_ptr + AW'(pop);
      level  <= level + LW'(push) - LW'(pop);
    end
  end

  // R7: nothing is offered for writing into a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> level < LW'(DEPTH))
    else $error("write into a full queue");

  // R6: the fill level never exceeds the depth
  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH))
    else $error("fill level out of range");

  // R8: a reset command leaves the queue empty
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> level == '0)
    else $error("queue not empty after reset command");

endmodule

// File: rtl/rxp_block_mon.sv
module rxp_block_mon
  import rxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] cfg_blk_code,
  input  logic       wr_en,
  output logic       blk_ready
);

  logic [1:0]       code_q;
  logic [BLK_W-1:0] cnt, size, cnt_inc;
  logic             hit;

  always_comb begin
    size    = blk_size(code_q);
    cnt_inc = cnt + BLK_W'(1);
    hit     = wr_en && (cnt_inc == size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q    <= 2'b00;
      cnt       <= '0;
      blk_ready <= 1'b0;
    end else if (load) begin
      code_q    <= cfg_blk_code;
      cnt       <= '0;
      blk_ready <= 1'b0;
    end else begin
      blk_ready <= hit;
      if (hit)        cnt <= '0;
      else if (wr_en) cnt <= cnt_inc;
    end
  end

  // R1: a block event always comes from a counted write
  p_blk_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> $past(wr_en) && !$past(load))
    else $error("block event without a counted write");

  // R2: the active code only moves on a command
  p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(code_q))
    else $error("block code changed without a command");

  // R1: the counter stays below the active size
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < size)
    else $error("block counter out of range");

endmodule

// File: rtl/hdlc_rx_packer.sv
module hdlc_rx_packer
  import rxp_pkg::*;
#(
  parameter int unsigned DEPTH = QUEUE_DEPTH,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  input  logic             in_abort,
  input  logic             cfg_store_addr,
  input  logic             cfg_store_crc,
  input  logic [1:0]       cfg_blk_code,
  input  logic             cmd_rx_reset,
  input  logic             cmd_msg_done,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic             rd_nonempty,
  output logic [LW-1:0]    rd_level,
  output logic             blk_ready,
  output logic             eof_evt,
  output logic [CNT_W-1:0] eof_count,
  output logic [7:0]       eof_status
);

  logic       q_wr, room_data, room_stat, blk_load;
  logic [7:0] q_wdata;

  assign blk_load = cmd_rx_reset || cmd_msg_done;

  rxp_frame_filter #(.CNT_W(CNT_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .flush(cmd_rx_reset),
    .in_valid(in_valid), .in_byte(in_byte), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_ok(in_crc_ok), .in_abort(in_abort),
    .cfg_store_addr(cfg_store_addr), .cfg_store_crc(cfg_store_crc),
    .room_data(room_data), .room_stat(room_stat),
    .wr_en(q_wr), .wr_data(q_wdata),
    .eof_evt(eof_evt), .eof_count(eof_count), .eof_status(eof_status)
  );

  rxp_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cmd_rx_reset),
    .wr_en(q_wr), .wr_data(q_wdata), .rd_en(rd_en),
    .rd_data(rd_data), .rd_nonempty(rd_nonempty), .level(rd_level),
    .room_data(room_data), .room_stat(room_stat)
  );

  rxp_block_mon u_blk (
    .clk(clk), .rst_n(rst_n), .load(blk_load), .cfg_blk_code(cfg_blk_code),
    .wr_en(q_wr), .blk_ready(blk_ready)
  );

  // R8: the reset command suppresses both events in the next cycle
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_rx_reset) |-> !blk_ready && !eof_evt)
    else $error("event after reset command");

endmodule

// File: tb/test_hdlc_rx_packer.sv
module test_hdlc_rx_packer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 0, in_sof = 0, in_eof = 0, in_crc_ok = 0, in_abort = 0;
  logic [7:0] in_byte = 8'h00;
  logic       cfg_store_addr = 0, cfg_store_crc = 0;
  logic [1:0] cfg_blk_code = 2'b00;
  logic       cmd_rx_reset = 0, cmd_msg_done = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic       rd_nonempty, blk_ready, eof_evt;
  logic [6:0] rd_level;
  logic [7:0] eof_count, eof_status;

  always #2 clk = ~clk;

  hdlc_rx_packer i_hdlc_rx_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_sof(in_sof), .in_eof(in_eof), .in_crc_ok(in_crc_ok), .in_abort(in_abort),
    .cfg_store_addr(cfg_store_addr), .cfg_store_crc(cfg_store_crc),
    .cfg_blk_code(cfg_blk_code), .cmd_rx_reset(cmd_rx_reset),
    .cmd_msg_done(cmd_msg_done), .rd_en(rd_en), .rd_data(rd_data),
    .rd_nonempty(rd_nonempty), .rd_level(rd_level), .blk_ready(blk_ready),
    .eof_evt(eof_evt), .eof_count(eof_count), .eof_status(eof_status)
  );

  int n_chk = 0, n_fail = 0;
  int blk_seen = 0, eof_seen = 0;
  logic [7:0] last_cnt, last_stat;
  logic [7:0] exp_q [0:255];
  int q_head = 0, q_tail = 0, m_level = 0;
  int blk_acc = 0, blk_sz = 32;
  int exp_cnt = 0;
  logic [7:0] exp_stat;

  always @(negedge clk) begin
    if (blk_ready) blk_seen++;
    if (eof_evt) begin
      eof_seen++;
      last_cnt  = eof_count;
      last_stat = eof_status;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic beat(input logic v, input logic [7:0] b, input logic s,
                      input logic e, input logic ok, input logic ab);
    in_valid = v; in_byte = b; in_sof = s; in_eof = e; in_crc_ok = ok; in_abort = ab;
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_crc_ok = 0; in_abort = 0;
  endtask

  task automatic command(input logic rst_cmd, input logic [1:0] code);
    cfg_blk_code = code;
    if (rst_cmd) cmd_rx_reset = 1; else cmd_msg_done = 1;
    @(negedge clk);
    cmd_rx_reset = 0; cmd_msg_done = 0;
    blk_acc = 0;
    blk_sz  = 32 >> code;
    if (rst_cmd) begin m_level = 0; q_head = q_tail; end
  endtask

  // Sends one frame and updates the bench model (queue contents, counts, pulses).
  task automatic send_frame(input int len, input logic sa, input logic sc,
                            input logic ok, input logic ab, input logic [7:0] seed,
                            input logic flip, input string req);
    int blk0, eof0, written;
    logic movf;
    blk0 = blk_seen; eof0 = eof_seen;
    movf = 0; exp_cnt = 0; written = 0;
    cfg_store_addr = sa; cfg_store_crc = sc;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 7);
      beat(1, b, i == 0, 0, 0, 0);
      if (flip && i == 0) cfg_store_crc = ~sc;
      if (!(i == 0 && !sa) && !(!sc && i >= len - 2)) begin
        if (!movf && m_level < 63) begin
          exp_q[q_tail[7:0]] = b; q_tail++; m_level++; exp_cnt++; written++;
        end else movf = 1;
      end
    end
    exp_stat = {5'b0, movf || m_level >= 64, ab, ok};
    if (m_level < 64) begin
      exp_q[q_tail[7:0]] = exp_stat; q_tail++; m_level++; written++;
    end
    beat(0, 8'h00, 0, 1, ok, ab);
    @(negedge clk);
    chk({req, " R5 eof event"}, eof_seen - eof0, 1);
    chk({req, " R5 eof_count"}, last_cnt, exp_cnt);
    chk({req, " R5 eof_status"}, last_stat, exp_stat);
    chk({req, " R1 block pulses"}, blk_seen - blk0, (blk_acc + written) / blk_sz);
    blk_acc = (blk_acc + written) % blk_sz;
  endtask

  task automatic drain(input string req);
    while (rd_nonempty) begin
      chk({req, " R6 head byte"}, rd_data, exp_q[q_head[7:0]]);
      q_head++;
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
    chk({req, " R6 all bytes drained"}, q_tail - q_head, 0);
    q_head = q_tail;
    m_level = 0;
  endtask

  // Vector fields: [15:8] length, [3] keep address, [2] keep CRC, [1] crc ok, [0] abort
  localparam logic [15:0] VEC [8] = '{
    {8'd5,  4'b0, 4'b1110}, {8'd6,  4'b0, 4'b0010}, {8'd3,  4'b0, 4'b0010},
    {8'd10, 4'b0, 4'b1001}, {8'd2,  4'b0, 4'b1010}, {8'd12, 4'b0, 4'b0110},
    {8'd1,  4'b0, 4'b1111}, {8'd20, 4'b0, 4'b1100}
  };

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    chk("R6 reset level", rd_level, 0);
    chk("R6 reset nonempty", rd_nonempty, 0);
    chk("R1 reset blk_ready", blk_ready, 0);
    chk("R5 reset eof_evt", eof_evt, 0);

    // Table walk, block size 8 (code 2'b10)
    command(1, 2'b10);
    foreach (VEC[k]) begin
      send_frame(int'(VEC[k][15:8]), VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0],
                 8'(k * 16 + 3), 0, "vec R3 R4");
      drain("vec");
    end

    // R2: staged code ignored until a command
    command(1, 2'b11);
    cfg_blk_code = 2'b01;
    send_frame(7, 1, 1, 1, 0, 8'h40, 0, "R2 staged");
    drain("R2 staged");
    command(0, 2'b01);
    send_frame(15, 1, 1, 1, 0, 8'h50, 0, "R2 size16");
    drain("R2 size16");
    command(0, 2'b00);
    send_frame(31, 1, 1, 0, 0, 8'h60, 0, "R2 size32");
    drain("R2 size32");

    // R4: CRC choice latched at frame start
    send_frame(6, 1, 0, 1, 0, 8'h70, 1, "R4 latched");
    drain("R4 latched");

    // R7: overflow of a long frame
    command(1, 2'b11);
    send_frame(70, 1, 1, 1, 0, 8'h11, 0, "R7 overflow");
    chk("R7 level full", rd_level, 64);
    drain("R7 overflow");

    // R8: reset command mid-frame
    cfg_store_addr = 1; cfg_store_crc = 1;
    begin
      int e0;
      e0 = eof_seen;
      for (int i = 0; i < 4; i++) beat(1, 8'(8'hA0 + i), i == 0, 0, 0, 0);
      chk("R8 level before flush", rd_level, 4);
      command(1, 2'b10);
      chk("R8 level after flush", rd_level, 0);
      chk("R8 nonempty after flush", rd_nonempty, 0);
      // R9: close strobe and bytes outside a frame
      beat(0, 8'h00, 0, 1, 1, 0);
      @(negedge clk);
      chk("R9 no eof outside frame", eof_seen - e0, 0);
      for (int i = 0; i < 3; i++) beat(1, 8'h55, 0, 0, 0, 0);
      @(negedge clk);
      chk("R9 stray bytes ignored", rd_level, 0);
    end

    // Normal operation resumes after the flush
    send_frame(4, 0, 1, 1, 0, 8'h21, 0, "R8 resume");
    drain("R8 resume");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule